// File: doc/BRIEF.md
# Coupled Two-Stage Delay Tap Stepper

This block walks a fine delay line toward a requested tap position, one tap at a time. Each fine step is paired with a coarse-line correction of twice the size in the opposite direction. The pairing keeps an alignment between strobe and clock that an earlier leveling pass set up. The block drives single-cycle increment and decrement pulses to both lines and keeps its own copy of both tap counts. It stops moving the coarse line when that line reaches an end of its range. When the fine line reaches the goal, the block signals completion and asks for a fresh leveling pass.

A caller sets a left limit, a right limit, a target and a settle count, then pulses `start_i`. The target is forced into the window set by the limits, and a status bit records whether it had to be moved. Each step runs in this order: one fine pulse, then up to two coarse pulses. Every pulse is followed by the programmed number of quiet cycles so that the delay line can settle. All control and status pins are plain levels or pulses. No streaming interface is involved.

Top module: `tapstep_stepper`

## Requirements
- R1: A synchronous active-high reset sets both tap counts to 0. After reset, `busy_o`, `done_o`, `relevel_req_o`, `clamped_o` and all four pulse outputs are 0.
- R2: When `start_i` is accepted, the goal becomes `lim_lo_i` if `target_i < lim_lo_i`, `lim_hi_i` if `target_i > lim_hi_i`, and `target_i` otherwise. `clamped_o` is 1 exactly when the goal differs from `target_i`. It holds that value until the next accepted start.
- R3: Each fine step moves the fine count by exactly one toward the goal. `fine_up_o` or `fine_dn_o` is high for one cycle, and in that same cycle `fine_tap_o` already shows the new value.
- R4: After a fine increment come two coarse decrements. After a fine decrement come two coarse increments. Each coarse pulse is high for one cycle, and `crs_tap_o` shows the new value in that same cycle.
- R5: The coarse count stays within 0 to 63. A correction that would pass a bound is cut short: no pulse is issued for the missing part. Fine stepping still continues.
- R6: Timing from an accepted start, counting cycles from the next one. There is one check cycle. For each fine step there is the fine pulse, then S settle cycles, where S is `settle_i` captured at start. Each coarse correction adds one cycle, then its pulse (if the coarse line is not at its bound), then S settle cycles. Then comes the next check cycle.
- R7: `busy_o` is high from the cycle after an accepted start through the final check cycle. In the next cycle, `done_o` and `relevel_req_o` are high for one cycle with `busy_o` low.
- R8: `start_i` is ignored while `busy_o` is high. The goal, taps and pulses continue unchanged.
- R9: A start whose goal equals the current fine count gives one busy cycle, then done, with no pulses.
- R10: At most one of the four pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when not busy |
| target_i | input | 6 | Requested fine tap |
| lim_lo_i | input | 6 | Left window limit |
| lim_hi_i | input | 6 | Right window limit |
| settle_i | input | 4 | Quiet cycles after each pulse |
| fine_up_o | output | 1 | Fine line increment pulse |
| fine_dn_o | output | 1 | Fine line decrement pulse |
| crs_up_o | output | 1 | Coarse line increment pulse |
| crs_dn_o | output | 1 | Coarse line decrement pulse |
| fine_tap_o | output | 6 | Tracked fine tap count |
| crs_tap_o | output | 6 | Tracked coarse tap count |
| busy_o | output | 1 | Stepping in progress |
| done_o | output | 1 | One-cycle completion pulse |
| relevel_req_o | output | 1 | One-cycle request for a new leveling pass |
| clamped_o | output | 1 | Goal was forced into the window |

## Verification
The assertions assume that `lim_lo_i` is never above `lim_hi_i` when a start is accepted. Under that assumption, a fine step can never leave the window or wrap the 6-bit count. The stimulus always sets the limits in that order. It changes limits, target and settle only while the block is idle, and holds them until a start has been taken. One stimulus issues a start in the middle of a run, to show that it is dropped. Another walks the fine line far enough that the coarse line reaches 0 and then 63.

// File: rtl/tapstep_pkg.sv
package tapstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETTLE,
    ST_CRS,
    ST_DONE
  } step_state_e;

endpackage

// File: rtl/tapstep_clamp.sv
module tapstep_clamp #(
  parameter int FINE_W = 6
) (
  input  logic [FINE_W-1:0] req_i,
  input  logic [FINE_W-1:0] lo_i,
  input  logic [FINE_W-1:0] hi_i,
  output logic [FINE_W-1:0] goal_o,
  output logic              moved_o
);
  always_comb begin
    if (req_i < lo_i) begin
      goal_o  = lo_i;
      moved_o = 1'b1;
    end else if (req_i > hi_i) begin
      goal_o  = hi_i;
      moved_o = 1'b1;
    end else begin
      goal_o  = req_i;
      moved_o = 1'b0;
    end
  end

  always_comb begin
    if (lo_i <= hi_i) begin
      a_goal_in_window_r2 : assert ((goal_o >= lo_i) && (goal_o <= hi_i));
    end
  end
endmodule

// File: rtl/tapstep_coarse_ctr.sv
module tapstep_coarse_ctr #(
  parameter int CRS_W   = 6,
  parameter int CRS_MAX = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CRS_W-1:0] tap_o,
  output logic             at_max_o,
  output logic             at_min_o
);
  localparam logic [CRS_W-1:0] TopVal = CRS_W'(CRS_MAX);

  logic [CRS_W-1:0] tap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= '0;
    end else if (inc_i && (tap_q != TopVal)) begin
      tap_q <= tap_q + 1'b1;
    end else if (dec_i && (tap_q != '0)) begin
      tap_q <= tap_q - 1'b1;
    end
  end

  assign tap_o    = tap_q;
  assign at_max_o = (tap_q == TopVal);
  assign at_min_o = (tap_q == '0);

  p_no_inc_at_top_r5 : assert property (@(posedge clk) disable iff (rst)
    inc_i |-> !at_max_o);
  p_no_dec_at_zero_r5 : assert property (@(posedge clk) disable iff (rst)
    dec_i |-> !at_min_o);
  p_range_r5 : assert property (@(posedge clk) disable iff (rst)
    tap_q <= TopVal);
endmodule

// File: rtl/tapstep_settle_tmr.sv
module tapstep_settle_tmr #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SET_W-1:0] val_i,
  output logic             zero_o
);
  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  p_count_down_r6 : assert property (@(posedge clk) disable iff (rst)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tapstep_stepper.sv
module tapstep_stepper
  import tapstep_pkg::*;
#(
  parameter int FINE_W  = 6,
  parameter int CRS_W   = 6,
  parameter int CRS_MAX = 63,
  parameter int SET_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [FINE_W-1:0] target_i,
  input  logic [FINE_W-1:0] lim_lo_i,
  input  logic [FINE_W-1:0] lim_hi_i,
  input  logic [SET_W-1:0]  settle_i,
  output logic              fine_up_o,
  output logic              fine_dn_o,
  output logic              crs_up_o,
  output logic              crs_dn_o,
  output logic [FINE_W-1:0] fine_tap_o,
  output logic [CRS_W-1:0]  crs_tap_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              relevel_req_o,
  output logic              clamped_o
);
  localparam int CORR_STEPS = 2;
  localparam int CORR_W     = $clog2(CORR_STEPS + 1);

  step_state_e       state_q;
  logic [FINE_W-1:0] fine_q;
  logic [FINE_W-1:0] goal_q;
  logic [SET_W-1:0]  settle_q;
  logic              clamped_q;
  logic              dir_up_q;
  logic [CORR_W-1:0] corr_left_q;
  logic              fi_q, fd_q, ci_q, cd_q;

  logic [FINE_W-1:0] goal_d;
  logic              moved_d;
  logic              accept;
  logic              crs_blocked;
  logic              crs_go;
  logic              tmr_load;
  logic              tmr_zero;
  logic              fine_go;
  logic              crs_at_max, crs_at_min;

  tapstep_clamp #(.FINE_W(FINE_W)) u_clamp (
    .req_i  (target_i),
    .lo_i   (lim_lo_i),
    .hi_i   (lim_hi_i),
    .goal_o (goal_d),
    .moved_o(moved_d)
  );

  assign accept      = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign fine_go     = (state_q == ST_CHECK) && (fine_q != goal_q);
  assign crs_blocked = dir_up_q ? crs_at_min : crs_at_max;
  assign crs_go      = (state_q == ST_CRS) && !crs_blocked;
  assign tmr_load    = fine_go || crs_go;

  tapstep_coarse_ctr #(.CRS_W(CRS_W), .CRS_MAX(CRS_MAX)) u_coarse (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (crs_go && !dir_up_q),
    .dec_i   (crs_go && dir_up_q),
    .tap_o   (crs_tap_o),
    .at_max_o(crs_at_max),
    .at_min_o(crs_at_min)
  );

  tapstep_settle_tmr #(.SET_W(SET_W)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .load_i(tmr_load),
    .val_i (settle_q),
    .zero_o(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fine_q      <= '0;
      goal_q      <= '0;
      settle_q    <= '0;
      clamped_q   <= 1'b0;
      dir_up_q    <= 1'b0;
      corr_left_q <= '0;
      fi_q        <= 1'b0;
      fd_q        <= 1'b0;
      ci_q        <= 1'b0;
      cd_q        <= 1'b0;
    end else begin
      fi_q <= 1'b0;
      fd_q <= 1'b0;
      ci_q <= crs_go && !dir_up_q;
      cd_q <= crs_go && dir_up_q;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            goal_q    <= goal_d;
            clamped_q <= moved_d;
            settle_q  <= settle_i;
            state_q   <= ST_CHECK;
          end else begin
            state_q   <= ST_IDLE;
          end
        end
        ST_CHECK: begin
          if (fine_q == goal_q) begin
            state_q <= ST_DONE;
          end else begin
            dir_up_q    <= (goal_q > fine_q);
            corr_left_q <= CORR_W'(CORR_STEPS);
            if (goal_q > fine_q) begin
              fine_q <= fine_q + 1'b1;
              fi_q   <= 1'b1;
            end else begin
              fine_q <= fine_q - 1'b1;
              fd_q   <= 1'b1;
            end
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            state_q <= (corr_left_q != '0) ? ST_CRS : ST_CHECK;
          end
        end
        ST_CRS: begin
          if (crs_blocked) begin
            corr_left_q <= '0;
            state_q     <= ST_CHECK;
          end else begin
            corr_left_q <= corr_left_q - 1'b1;
            state_q     <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fine_up_o     = fi_q;
  assign fine_dn_o     = fd_q;
  assign crs_up_o      = ci_q;
  assign crs_dn_o      = cd_q;
  assign fine_tap_o    = fine_q;
  assign busy_o        = (state_q == ST_CHECK) || (state_q == ST_SETTLE) || (state_q == ST_CRS);
  assign done_o        = (state_q == ST_DONE);
  assign relevel_req_o = (state_q == ST_DONE);
  assign clamped_o     = clamped_q;

  p_single_pulse_r10 : assert property (@(posedge clk) disable iff (rst)
    $onehot0({fi_q, fd_q, ci_q, cd_q}));
  p_fine_up_step_r3 : assert property (@(posedge clk) disable iff (rst)
    fine_up_o |-> (fine_tap_o == $past(fine_tap_o) + 1'b1));
  p_fine_dn_step_r3 : assert property (@(posedge clk) disable iff (rst)
    fine_dn_o |-> (fine_tap_o == $past(fine_tap_o) - 1'b1));
  p_crs_up_tracks_r4 : assert property (@(posedge clk) disable iff (rst)
    crs_up_o |-> (crs_tap_o == $past(crs_tap_o) + 1'b1) && !dir_up_q);
  p_crs_dn_tracks_r4 : assert property (@(posedge clk) disable iff (rst)
    crs_dn_o |-> (crs_tap_o == $past(crs_tap_o) - 1'b1) && dir_up_q);
  p_done_at_goal_r7 : assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && (fine_tap_o == goal_q)));
  p_start_ignored_r8 : assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(goal_q) && $stable(clamped_q));
endmodule

// File: tb/tapstep_stepper_tb_top.sv
module tapstep_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [5:0] target_i, lim_lo_i, lim_hi_i;
  logic [3:0] settle_i;
  logic       fine_up_o, fine_dn_o, crs_up_o, crs_dn_o;
  logic [5:0] fine_tap_o, crs_tap_o;
  logic       busy_o, done_o, relevel_req_o, clamped_o;

  always #10 clk = ~clk;

  tapstep_stepper dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
    .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .settle_i(settle_i),
    .fine_up_o(fine_up_o), .fine_dn_o(fine_dn_o), .crs_up_o(crs_up_o),
    .crs_dn_o(crs_dn_o), .fine_tap_o(fine_tap_o), .crs_tap_o(crs_tap_o),
    .busy_o(busy_o), .done_o(done_o), .relevel_req_o(relevel_req_o),
    .clamped_o(clamped_o)
  );

  typedef struct packed {
    logic       busy;
    logic       done;
    logic       fu, fd, cu, cd;
    logic [5:0] fine;
    logic [5:0] crs;
  } exp_t;

  exp_t q[$];
  int   m_fine, m_crs, m_goal;
  logic m_clamp;
  int   n_tests = 0, n_fail = 0;
  int   cyc = 0;
  bit   wd_hit = 0;

  function automatic exp_t mk(logic b, logic d, logic fu, logic fd,
                              logic cu, logic cd, int f, int c);
    exp_t e;
    e.busy = b; e.done = d; e.fu = fu; e.fd = fd; e.cu = cu; e.cd = cd;
    e.fine = 6'(f); e.crs = 6'(c);
    return e;
  endfunction

  // Behavioural expectation of an accepted run (R2..R7).
  task automatic plan_run(int tgt, int lo, int hi, int s);
    int f, c;
    bit up;
    f = m_fine; c = m_crs;
    m_goal  = (tgt < lo) ? lo : (tgt > hi) ? hi : tgt;
    m_clamp = (m_goal != tgt);
    q.push_back(mk(1, 0, 0, 0, 0, 0, f, c));
    while (f != m_goal) begin
      up = (m_goal > f);
      f  = up ? f + 1 : f - 1;
      q.push_back(mk(1, 0, up, !up, 0, 0, f, c));
      for (int i = 0; i < s; i++) q.push_back(mk(1, 0, 0, 0, 0, 0, f, c));
      for (int k = 0; k < 2; k++) begin
        q.push_back(mk(1, 0, 0, 0, 0, 0, f, c));
        if (up ? (c == 0) : (c == 63)) break;
        c = up ? c - 1 : c + 1;
        q.push_back(mk(1, 0, 0, 0, !up, up, f, c));
        for (int i = 0; i < s; i++) q.push_back(mk(1, 0, 0, 0, 0, 0, f, c));
      end
      q.push_back(mk(1, 0, 0, 0, 0, 0, f, c));
    end
    q.push_back(mk(0, 1, 0, 0, 0, 0, f, c));
    m_fine = f; m_crs = c;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_fine = 0; m_crs = 0; m_clamp = 0;
    end else if (start_i && q.size() == 0) begin
      plan_run(int'(target_i), int'(lim_lo_i), int'(lim_hi_i), int'(settle_i));
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (!rst) begin
      if (q.size() > 0) e = q.pop_front();
      else e = mk(0, 0, 0, 0, 0, 0, m_fine, m_crs);
      chk(fine_up_o == e.fu && fine_dn_o == e.fd, "R3 R6 fine pulse",
          {fine_up_o, fine_dn_o}, {e.fu, e.fd});
      chk(crs_up_o == e.cu && crs_dn_o == e.cd, "R4 R5 coarse pulse",
          {crs_up_o, crs_dn_o}, {e.cu, e.cd});
      chk(fine_tap_o == e.fine, "R3 fine tap", fine_tap_o, e.fine);
      chk(crs_tap_o == e.crs, "R4 R5 coarse tap", crs_tap_o, e.crs);
      chk(busy_o == e.busy, "R7 busy", busy_o, e.busy);
      chk(done_o == e.done && relevel_req_o == e.done, "R7 done/relevel",
          {done_o, relevel_req_o}, {e.done, e.done});
      chk(clamped_o == m_clamp, "R2 clamp flag", clamped_o, m_clamp);
      chk($countones({fine_up_o, fine_dn_o, crs_up_o, crs_dn_o}) <= 1,
          "R10 pulse exclusivity",
          $countones({fine_up_o, fine_dn_o, crs_up_o, crs_dn_o}), 1);
    end
  end

  task automatic go(int tgt, int lo, int hi, int s);
    @(negedge clk);
    target_i = 6'(tgt); lim_lo_i = 6'(lo); lim_hi_i = 6'(hi); settle_i = 4'(s);
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0;
    target_i = '0; lim_lo_i = '0; lim_hi_i = 6'd63; settle_i = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(fine_tap_o == 0 && crs_tap_o == 0, "R1 taps after reset", fine_tap_o + crs_tap_o, 0);
    chk(!busy_o && !done_o && !relevel_req_o && !clamped_o && !fine_up_o
        && !fine_dn_o && !crs_up_o && !crs_dn_o, "R1 outputs after reset", busy_o, 0);
    rst = 1'b0;
    // R5: coarse already at 0, fine climbs alone
    go(10, 0, 63, 2);
    // R2: target above right limit clamps to 40
    go(55, 0, 40, 1);
    chk(fine_tap_o == 40, "R2 clamp to right limit", fine_tap_o, 40);
    // R5: descending to 0 drives coarse up until it stops at 63
    go(0, 0, 63, 0);
    chk(crs_tap_o == 63, "R5 coarse saturates at 63", crs_tap_o, 63);
    // R2: target below left limit clamps to 5
    go(1, 5, 30, 1);
    chk(fine_tap_o == 5 && clamped_o, "R2 clamp to left limit", fine_tap_o, 5);
    // R9: start at current tap
    go(5, 0, 63, 3);
    chk(!clamped_o && fine_tap_o == 5, "R9 no movement at goal", fine_tap_o, 5);
    // R8: a second start in mid-run is dropped
    @(negedge clk);
    target_i = 6'd9; lim_lo_i = 0; lim_hi_i = 63; settle_i = 4'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    target_i = 6'd20; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk(fine_tap_o == 9, "R8 mid-run start ignored", fine_tap_o, 9);
    // R6: zero-settle and longer-settle runs in both directions
    go(3, 0, 63, 4);
    go(12, 2, 50, 0);
    repeat (5) @(negedge clk);
    if (!wd_hit) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule